// File: doc/BRIEF.md
# UART Modem Control and Status Registers

This block holds the modem control byte and the modem status byte of a 16550-style serial port behind a small byte-wide register bus. The read and write sides of the bus each carry their own address, so that one read and one write can happen in the same cycle. There is a single error flag. The transmit and receive path, the FIFOs, baud timing, line status and interrupt logic are not part of this block.

There are no real modem pins. When loopback is enabled, the status lines follow the control outputs written by software. When loopback is off, the status lines sit at a fixed state: carrier detect, data-set-ready and clear-to-send are high, and ring is low. The status byte therefore changes only when the control byte is written. Each such write also computes change flags against the status held just before the write. A read of the status byte returns it and then clears those flags.

A control write that sets an unsupported bit still succeeds. The unsupported bits are dropped, and the block raises a one-cycle warning pulse. The block has no state machine: its behaviour is two registers and the update rules between them.

Top module: `modem_ctl_regs`

## Requirements
- R1: After reset, the control byte reads 0x00 and the status byte reads 0xB0.
- R2: A control write at address 4 stores the written byte ANDed with 0x1F. The bits are 0 dtr, 1 rts, 2 out1, 3 out2 and 4 loop. A read at address 4 returns the stored value in the same cycle, with err low.
- R3: In the cycle after a control write with any of bits 7:5 set, warn is high for exactly one cycle. After any other cycle, warn is low.
- R4: The status byte has bits 0 dcts, 1 ddsr, 2 teri, 3 ddcd, 4 cts, 5 dsr, 6 ri and 7 dcd. With loop set, a control write makes cts equal rts, dsr equal dtr, ri equal out1 and dcd equal out2.
- R5: With loop clear, a control write makes the upper status nibble 0xB (dcd, dsr and cts high, ri low), whatever the other control bits are.
- R6: A control write sets dcts, ddsr and ddcd exactly where cts, dsr and dcd differ between the old and new status. The previous change bits are replaced, not accumulated.
- R7: A control write sets teri only when ri goes from 1 in the old status to 0 in the new status.
- R8: A read at address 6 returns the full status byte in the same cycle. From the next cycle the change bits 3:0 are clear and bits 7:4 are unchanged.
- R9: A write at address 6 raises err in the same cycle and leaves both registers unchanged.
- R10: A read or write at any address other than 4 and 6 raises err in the same cycle. Such a read returns 0x00, and such a write changes nothing.
- R11: When a control write and a status read fall in the same cycle, the read returns the old status. The change bits computed by the write are kept and are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| err | output | 1 | Access error, same cycle as the strobe |
| warn | output | 1 | One-cycle pulse after a control write with unsupported bits |

## Verification
The bench builds the block with its default 3-bit address and offsets 4 and 6, which puts the whole address space within reach: every mapped and unmapped address is probed for reads and writes. For each of the 32 stored control values, it steps through all 256 write bytes in turn. That covers every pair of old and new status, every loopback mapping, every delta and trailing-ring case, and the delta-replacement rule. Same-cycle read and write collisions are then exercised separately.

// File: rtl/modem_pkg.sv
package modem_pkg;
    localparam int BYTE_W = 8;
    localparam int LINE_W = 4;

    // line nibble positions: cts, dsr, ri, dcd
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;
    localparam int CTL_W   = 5;

    localparam logic [LINE_W-1:0] LINE_IDLE = 4'b1011;
    localparam logic [BYTE_W-1:0] MSR_RESET = {LINE_IDLE, 4'b0000};
endpackage

// File: rtl/modem_ctl_decode.sv
module modem_ctl_decode
    import modem_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int MCR_OFS = 4,
    parameter int MSR_OFS = 6
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTL_W-1:0]  ctl_q,
    input  logic [BYTE_W-1:0] msr_q,
    output logic              ctl_wr,
    output logic              msr_rd,
    output logic [BYTE_W-1:0] rdata,
    output logic              err
);
    localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_OFS);
    localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_OFS);

    logic rd_ctl;

    always_comb begin
        rd_ctl = rd_en && (rd_addr == A_MCR);
        msr_rd = rd_en && (rd_addr == A_MSR);
        ctl_wr = wr_en && (wr_addr == A_MCR);
        err    = (rd_en && !rd_ctl && !msr_rd) || (wr_en && !ctl_wr);
        if (rd_ctl)
            rdata = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
        else if (msr_rd)
            rdata = msr_q;
        else
            rdata = '0;
    end
endmodule

// File: rtl/modem_ctl_mcr.sv
module modem_ctl_mcr
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [CTL_W-1:0]  ctl_next,
    output logic              warn
);
    logic bad_bits;

    always_comb begin
        ctl_next = wdata[CTL_W-1:0];
        bad_bits = |wdata[BYTE_W-1:CTL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            warn  <= 1'b0;
        end else begin
            warn <= ctl_wr && bad_bits;
            if (ctl_wr)
                ctl_q <= ctl_next;
        end
    end

    AST_WARN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && !$past(ctl_wr)) |-> 1'b0); // R3
endmodule

// File: rtl/modem_ctl_msr.sv
module modem_ctl_msr
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_next,
    input  logic              msr_rd,
    output logic [BYTE_W-1:0] msr_q
);
    logic [LINE_W-1:0] line_old;
    logic [LINE_W-1:0] line_new;
    logic [LINE_W-1:0] delta;

    always_comb begin
        line_old = msr_q[BYTE_W-1:LINE_W];
        if (ctl_next[CB_LOOP]) begin
            line_new[LN_CTS] = ctl_next[CB_RTS];
            line_new[LN_DSR] = ctl_next[CB_DTR];
            line_new[LN_RI]  = ctl_next[CB_OUT1];
            line_new[LN_DCD] = ctl_next[CB_OUT2];
        end else begin
            line_new = LINE_IDLE;
        end
    end

    for (genvar i = 0; i < LINE_W; i++) begin : g_delta
        if (i == LN_RI) begin : g_trail
            assign delta[i] = line_old[i] & ~line_new[i];
        end else begin : g_change
            assign delta[i] = line_old[i] ^ line_new[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            msr_q <= MSR_RESET;
        else if (ctl_wr)
            msr_q <= {line_new, delta};
        else if (msr_rd)
            msr_q[LINE_W-1:0] <= '0;
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !ctl_wr) |=> (msr_q[3:0] == 4'b0) &&
                                (msr_q[7:4] == $past(msr_q[7:4]))); // R8
    AST_TERI_RI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        msr_q[2] |-> !msr_q[6]); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && msr_rd) |=> msr_q[3:0] == $past(delta)); // R11
endmodule

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
    import modem_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int MCR_OFS = 4,
    parameter int MSR_OFS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              err,
    output logic              warn
);
    logic              ctl_wr;
    logic              msr_rd;
    logic [CTL_W-1:0]  ctl_q;
    logic [CTL_W-1:0]  ctl_next;
    logic [BYTE_W-1:0] msr_q;

    modem_ctl_decode #(
        .ADDR_W (ADDR_W),
        .MCR_OFS(MCR_OFS),
        .MSR_OFS(MSR_OFS)
    ) u_dec (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .ctl_q  (ctl_q),
        .msr_q  (msr_q),
        .ctl_wr (ctl_wr),
        .msr_rd (msr_rd),
        .rdata  (rdata),
        .err    (err)
    );

    modem_ctl_mcr u_mcr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .wdata   (wdata),
        .ctl_q   (ctl_q),
        .ctl_next(ctl_next),
        .warn    (warn)
    );

    modem_ctl_msr u_msr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_next(ctl_next),
        .msr_rd  (msr_rd),
        .msr_q   (msr_q)
    );

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[CB_LOOP] |-> msr_q[7:4] == LINE_IDLE); // R5
    AST_LOOP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CB_LOOP] |-> msr_q[7:4] ==
            {ctl_q[CB_OUT2], ctl_q[CB_OUT1], ctl_q[CB_DTR], ctl_q[CB_RTS]}); // R4
    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && err && !msr_rd) |=> $stable(ctl_q) && $stable(msr_q)); // R9
endmodule

// File: tb/modem_ctl_regs_test.sv
module modem_ctl_regs_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       err;
    logic       warn;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_mcr;
    logic [7:0] m_msr;

    modem_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
        .rdata(rdata), .err(err), .warn(warn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] line_of(input logic [7:0] m);
        if (m[4]) return {m[3], m[2], m[0], m[1]};
        return 4'b1011;
    endfunction

    function automatic logic [7:0] next_msr(input logic [7:0] old, input logic [7:0] m);
        logic [3:0] o, n;
        o = old[7:4];
        n = line_of(m);
        return {n, o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    // all tasks start and end 1 time unit after a rising edge
    task automatic wr_ctl(input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = 3'd4; wdata = d;
        #1;
        check({tag, " err"}, {7'b0, err}, 8'h00);
        @(posedge clk); #1;
        wr_en = 1'b0;
        check("R3 warn", {7'b0, warn}, {7'b0, |d[7:5]});
        m_msr = next_msr(m_msr, d);
        m_mcr = d & 8'h1F;
    endtask

    task automatic rd_at(input logic [2:0] a, input logic [7:0] exp, input logic exp_err,
                         input string tag);
        rd_en = 1'b1; rd_addr = a;
        #1;
        check(tag, rdata, exp);
        check({tag, " err"}, {7'b0, err}, {7'b0, exp_err});
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (a == 3'd6) m_msr = m_msr & 8'hF0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_mcr = 8'h00;
        m_msr = 8'hB0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset values
        check("R1 warn", {7'b0, warn}, 8'h00);
        rd_at(3'd4, 8'h00, 1'b0, "R1 mcr");
        rd_at(3'd6, 8'hB0, 1'b0, "R1 msr");

        // R10 unmapped reads and writes
        for (int a = 0; a < 8; a++) begin
            if (a != 4 && a != 6) begin
                rd_at(3'(a), 8'h00, 1'b1, "R10 read");
                wr_en = 1'b1; wr_addr = 3'(a); wdata = 8'hFF;
                #1 check("R10 write err", {7'b0, err}, 8'h01);
                @(posedge clk); #1 wr_en = 1'b0;
                check("R10 no warn", {7'b0, warn}, 8'h00);
            end
        end
        rd_at(3'd4, m_mcr, 1'b0, "R10 mcr kept");
        rd_at(3'd6, m_msr, 1'b0, "R10 msr kept");

        // R9 write to the status address
        wr_ctl(8'h1F, "R9 setup");
        wr_en = 1'b1; wr_addr = 3'd6; wdata = 8'h00;
        #1 check("R9 err", {7'b0, err}, 8'h01);
        @(posedge clk); #1 wr_en = 1'b0;
        rd_at(3'd6, m_msr, 1'b0, "R9 msr kept");
        rd_at(3'd4, m_mcr, 1'b0, "R9 mcr kept");

        // R2 R4 R5 R6 R7 R8: every old control value against every written byte
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 256; b++) begin
                wr_ctl(8'(a), "R6 first");
                wr_ctl(8'(b), "R2 second");
                rd_at(3'd6, m_msr, 1'b0, "R4 R5 R6 R7 msr");
                rd_at(3'd4, m_mcr, 1'b0, "R2 mcr");
            end
        end
        rd_at(3'd6, m_msr, 1'b0, "R8 cleared");

        // R11 same-cycle control write and status read
        for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = (k == 0) ? 8'h14 : (k == 1) ? 8'h00 : (k == 2) ? 8'h1F : 8'h13;
            wr_ctl(8'h1C, "R11 setup");
            rd_at(3'd6, m_msr, 1'b0, "R11 pre");
            wr_en = 1'b1; wr_addr = 3'd4; wdata = d;
            rd_en = 1'b1; rd_addr = 3'd6;
            #1 check("R11 old value", rdata, m_msr);
            @(posedge clk); #1;
            wr_en = 1'b0; rd_en = 1'b0;
            m_msr = next_msr(m_msr, d);
            m_mcr = d;
            rd_at(3'd6, m_msr, 1'b0, "R11 deltas kept");
        end

        // R3 warn for each unsupported bit, then back low
        for (int k = 5; k < 8; k++) begin
            wr_ctl(8'h01 << k, "R3 bit");
            @(posedge clk); #1;
            check("R3 pulse ends", {7'b0, warn}, 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule